// File: doc/BRIEF.md
# Serial FIFO Status Flag and Interrupt Controller

This block holds the status flags of a FIFO-buffered serial port and turns them into interrupt and DMA requests. It watches the live fill counts of the transmit and receive FIFOs, compares each count against a threshold picked by a 2-bit trigger select, and latches "transmit room available" and "receive data full" flags. Receive error, break, overrun and data-ready events latch their own flags.

Software clears a flag in two steps. It first reads the status register while the flag is 1, then writes 0 to that bit. A write of 0 to a flag that has not been read as 1 leaves it set. A level flag whose threshold condition still holds after a clear stays at 1. The flags are merged onto four interrupt lines, each gated by its own enable bit. DMA requests are raised only for the two data-moving sources. A priority encoder reports the most urgent pending line.

A second readable register reports both FIFO fill counts. The shifters, the baud generator and the FIFO storage are outside this block and are seen only through the count and event inputs.

Top module: `sfifo_stat_irq`

## Requirements
- R1: Status bit 0 (transmit room) becomes 1 one cycle after `tx_count_i` is at or below the transmit threshold. Trigger select 0, 1, 2 and 3 give thresholds 8, 4, 2 and 0.
- R2: Status bit 1 (receive full) becomes 1 one cycle after `rx_count_i` is at or above the receive threshold. Trigger select 0, 1, 2 and 3 give thresholds 1, 4, 8 and 14.
- R3: A one-cycle pulse latches a status bit that stays at 1 until it is cleared. `rx_ready_i` latches bit 2, `rx_err_i` bit 3, `brk_i` bit 4 and `ovr_i` bit 5.
- R4: A status bit is cleared in two steps. First a read of address 0 (`reg_rd_i`=1) happens while the bit is 1. A later write to address 0 with that data bit 0 then clears it, seen on the next cycle. Writing 1 to a bit leaves it unchanged.
- R5: Writing 0 to a status bit that has not been read as 1 since it last set leaves the bit at 1.
- R6: If a level flag (bit 0 or 1) is cleared while its threshold condition still holds, it still reads 1 on the next cycle.
- R7: `reg_rdata_o` shows the selected register at all times. Address 0 gives the six status bits in [5:0] with zeros above. Address 1 gives the transmit count in [15:8] and the receive count in [7:0].
- R8: `irq_err_o` is status bit 3 ANDed with `irq_en_i[0]`.
- R9: `irq_rx_o` is (bit 1, or bit 2 when `async_mode_i`=1) ANDed with `irq_en_i[1]`. Bit 2 has no effect on the line when `async_mode_i`=0.
- R10: `irq_brk_o` is (bit 4 OR bit 5) ANDed with `irq_en_i[2]`. `irq_tx_o` is bit 0 ANDed with `irq_en_i[3]`.
- R11: `dma_rx_o` is bit 1 ANDed with `irq_en_i[1]`, and `dma_tx_o` equals `irq_tx_o`. No DMA request comes from bits 2 to 5.
- R12: `irq_any_o` is 1 when any interrupt line is high. `irq_id_o` then names the highest-priority line: 0 error, 1 receive, 2 break, 3 transmit, where 0 is highest. With no line high, `irq_id_o` is 0.
- R13: While `rst_ni` is 0, all status bits and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_count_i | input | 5 | Transmit FIFO fill count |
| rx_count_i | input | 5 | Receive FIFO fill count |
| tx_trig_i | input | 2 | Transmit threshold select |
| rx_trig_i | input | 2 | Receive threshold select |
| async_mode_i | input | 1 | Port runs in asynchronous mode |
| rx_err_i | input | 1 | Receive error event pulse |
| brk_i | input | 1 | Break detected pulse |
| ovr_i | input | 1 | Receive overrun pulse |
| rx_ready_i | input | 1 | Data-ready event pulse |
| irq_en_i | input | 4 | Line enables: [0] error, [1] receive, [2] break, [3] transmit |
| reg_addr_i | input | 1 | Register select: 0 status, 1 counts |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 6 | Status write data |
| reg_rdata_o | output | 16 | Selected register contents |
| irq_err_o | output | 1 | Error interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_brk_o | output | 1 | Break/overrun interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| dma_rx_o | output | 1 | Receive DMA request |
| dma_tx_o | output | 1 | Transmit DMA request |
| irq_any_o | output | 1 | Any interrupt pending |
| irq_id_o | output | 2 | Highest-priority pending line |

## Verification
The fill counts are stepped across each threshold for more than one trigger select. A count one past the threshold must leave the flag clear and the threshold value itself must set it, which shows whether each compare is inclusive. The clear protocol is run three ways: read then write 0, write 0 with no prior read, and read then write 0 while the level condition still holds. These three cases separate a real clear from a missing arm check and from a missing re-set. Event pulses are combined so that several lines are pending at once, with enables and the asynchronous mode toggled. This checks the line merging, the priority encoder and the rule that DMA requests come only from the data flags.

// File: rtl/sfsi_pkg.sv
package sfsi_pkg;

  localparam int NFLAG     = 6;
  localparam int CNT_HALF  = 8;
  localparam int RD_W      = 2 * CNT_HALF;

  localparam int FL_TXE  = 0;
  localparam int FL_RXF  = 1;
  localparam int FL_DRDY = 2;
  localparam int FL_ERR  = 3;
  localparam int FL_BRK  = 4;
  localparam int FL_OVR  = 5;

  typedef enum logic [1:0] {
    SRC_ERR = 2'd0,
    SRC_RX  = 2'd1,
    SRC_BRK = 2'd2,
    SRC_TX  = 2'd3
  } irq_src_e;

  function automatic int rx_thr(input int depth, input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  function automatic int tx_thr(input int depth, input logic [1:0] sel);
    case (sel)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return depth / 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sfsi_level_cmp.sv
module sfsi_level_cmp #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter bit IS_TX = 1'b0
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       sel_i,
  output logic             hit_o
);
  import sfsi_pkg::*;

  generate
    if (IS_TX) begin : g_tx
      // room available: count at or below the transmit threshold
      always_comb hit_o = (cnt_i <= CNT_W'(tx_thr(DEPTH, sel_i)));
    end else begin : g_rx
      // enough data: count at or above the receive threshold
      always_comb hit_o = (cnt_i >= CNT_W'(rx_thr(DEPTH, sel_i)));
    end
  endgenerate

endmodule

// File: rtl/sfsi_flag.sv
module sfsi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  logic armed_q, armed_d, q_d, clr_fire;

  always_comb begin
    clr_fire = wr_i & ~wbit_i & armed_q;
    q_d      = set_i | (q_o & ~clr_fire);
    armed_d  = q_o & ~clr_fire & (armed_q | rd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      q_o     <= q_d;
      armed_q <= armed_d;
    end
  end

  AST_NO_CLEAR_UNREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o ##1 (q_o && wr_i && !wbit_i)) |=> q_o); // R5

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R6

endmodule

// File: rtl/sfsi_irq_route.sv
module sfsi_irq_route
  import sfsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [3:0]       en_i,
  input  logic             async_i,
  output logic             irq_err_o,
  output logic             irq_rx_o,
  output logic             irq_brk_o,
  output logic             irq_tx_o,
  output logic             dma_rx_o,
  output logic             dma_tx_o,
  output logic             irq_any_o,
  output irq_src_e         irq_id_o
);

  always_comb begin
    irq_err_o = flags_i[FL_ERR] & en_i[SRC_ERR];
    irq_rx_o  = (flags_i[FL_RXF] | (flags_i[FL_DRDY] & async_i)) & en_i[SRC_RX];
    irq_brk_o = (flags_i[FL_BRK] | flags_i[FL_OVR]) & en_i[SRC_BRK];
    irq_tx_o  = flags_i[FL_TXE] & en_i[SRC_TX];
    dma_rx_o  = flags_i[FL_RXF] & en_i[SRC_RX];
    dma_tx_o  = irq_tx_o;
    irq_any_o = irq_err_o | irq_rx_o | irq_brk_o | irq_tx_o;
  end

  always_comb begin
    if (irq_err_o)      irq_id_o = SRC_ERR;
    else if (irq_rx_o)  irq_id_o = SRC_RX;
    else if (irq_brk_o) irq_id_o = SRC_BRK;
    else if (irq_tx_o)  irq_id_o = SRC_TX;
    else                irq_id_o = SRC_ERR;
  end

  AST_PRIO_TX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_any_o && irq_id_o == SRC_TX) |-> !(irq_err_o || irq_rx_o || irq_brk_o)); // R12

  AST_DMA_DATA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_rx_o |-> irq_rx_o) and (dma_tx_o |-> irq_tx_o)); // R11

endmodule

// File: rtl/sfifo_stat_irq.sv
module sfifo_stat_irq
  import sfsi_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [1:0]       tx_trig_i,
  input  logic [1:0]       rx_trig_i,
  input  logic             async_mode_i,
  input  logic             rx_err_i,
  input  logic             brk_i,
  input  logic             ovr_i,
  input  logic             rx_ready_i,
  input  logic [3:0]       irq_en_i,
  input  logic             reg_addr_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [NFLAG-1:0] reg_wdata_i,
  output logic [RD_W-1:0]  reg_rdata_o,
  output logic             irq_err_o,
  output logic             irq_rx_o,
  output logic             irq_brk_o,
  output logic             irq_tx_o,
  output logic             dma_rx_o,
  output logic             dma_tx_o,
  output logic             irq_any_o,
  output logic [1:0]       irq_id_o
);

  localparam int PAD_W = CNT_HALF - CNT_W;

  logic             tx_hit, rx_hit, rd_stat, wr_stat;
  logic [NFLAG-1:0] set_vec, stat_q;
  irq_src_e         id_enc;

  sfsi_level_cmp #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_cmp (
    .cnt_i(tx_count_i), .sel_i(tx_trig_i), .hit_o(tx_hit)
  );

  sfsi_level_cmp #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_cmp (
    .cnt_i(rx_count_i), .sel_i(rx_trig_i), .hit_o(rx_hit)
  );

  always_comb begin
    rd_stat           = reg_rd_i & (reg_addr_i == 1'b0);
    wr_stat           = reg_wr_i & (reg_addr_i == 1'b0);
    set_vec           = '0;
    set_vec[FL_TXE]   = tx_hit;
    set_vec[FL_RXF]   = rx_hit;
    set_vec[FL_DRDY]  = rx_ready_i;
    set_vec[FL_ERR]   = rx_err_i;
    set_vec[FL_BRK]   = brk_i;
    set_vec[FL_OVR]   = ovr_i;
  end

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      sfsi_flag u_flag (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (set_vec[i]),
        .rd_i  (rd_stat),
        .wr_i  (wr_stat),
        .wbit_i(reg_wdata_i[i]),
        .q_o   (stat_q[i])
      );
    end
  endgenerate

  sfsi_irq_route u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (stat_q),
    .en_i     (irq_en_i),
    .async_i  (async_mode_i),
    .irq_err_o(irq_err_o),
    .irq_rx_o (irq_rx_o),
    .irq_brk_o(irq_brk_o),
    .irq_tx_o (irq_tx_o),
    .dma_rx_o (dma_rx_o),
    .dma_tx_o (dma_tx_o),
    .irq_any_o(irq_any_o),
    .irq_id_o (id_enc)
  );

  always_comb begin
    irq_id_o = id_enc;
    if (reg_addr_i)
      reg_rdata_o = {{PAD_W{1'b0}}, tx_count_i, {PAD_W{1'b0}}, rx_count_i};
    else
      reg_rdata_o = {{(RD_W-NFLAG){1'b0}}, stat_q};
  end

  AST_TXE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_hit |=> stat_q[FL_TXE]); // R1

  AST_RXF_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_hit |=> stat_q[FL_RXF]); // R2

  AST_EVENT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_i || brk_i) |=> (stat_q[FL_ERR] || !rx_err_i) && (stat_q[FL_BRK] || !brk_i)); // R3

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (stat_q == '0 && !irq_any_o && !dma_rx_o && !dma_tx_o)); // R13

endmodule

// File: tb/sfifo_stat_irq_bench.sv
module sfifo_stat_irq_bench;

  typedef struct {
    string       tag;
    logic [15:0] rd;
    logic [8:0]  irq;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  txc = 5'd16, rxc = 5'd0;
  logic [1:0]  tsel = 2'd0, rsel = 2'd0;
  logic        async_m = 1'b1;
  logic        ev_err = 0, ev_brk = 0, ev_ovr = 0, ev_rdy = 0;
  logic [3:0]  en = 4'b1111;
  logic        addr = 0, rd = 0, wr = 0;
  logic [5:0]  wd = 6'h3F;
  logic [15:0] rdata;
  logic        o_err, o_rx, o_brk, o_tx, o_drx, o_dtx, o_any;
  logic [1:0]  o_id;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t sbq[$];
  exp_t e;

  logic [5:0] m_q = '0;
  logic [5:0] m_arm = '0;

  always #5 clk = ~clk;

  sfifo_stat_irq u_sfifo_stat_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_count_i(txc), .rx_count_i(rxc), .tx_trig_i(tsel), .rx_trig_i(rsel),
    .async_mode_i(async_m), .rx_err_i(ev_err), .brk_i(ev_brk), .ovr_i(ev_ovr),
    .rx_ready_i(ev_rdy), .irq_en_i(en), .reg_addr_i(addr), .reg_rd_i(rd),
    .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .irq_err_o(o_err), .irq_rx_o(o_rx), .irq_brk_o(o_brk), .irq_tx_o(o_tx),
    .dma_rx_o(o_drx), .dma_tx_o(o_dtx), .irq_any_o(o_any), .irq_id_o(o_id)
  );

  function automatic int tx_lim(input logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 4; 2'd2: return 2; default: return 0; endcase
  endfunction

  function automatic int rx_lim(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  // expected {err, rx, brk, tx, dma_rx, dma_tx, any, id[1:0]}
  function automatic logic [8:0] exp_irq(input logic [5:0] q);
    logic e0, e1, e2, e3;
    logic [1:0] id;
    e0 = q[3] & en[0];
    e1 = (q[1] | (q[2] & async_m)) & en[1];
    e2 = (q[4] | q[5]) & en[2];
    e3 = q[0] & en[3];
    id = e0 ? 2'd0 : e1 ? 2'd1 : e2 ? 2'd2 : e3 ? 2'd3 : 2'd0;
    return {e0, e1, e2, e3, q[1] & en[1], e3, e0 | e1 | e2 | e3, id};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [5:0] q);
    return addr ? {3'b0, txc, 3'b0, rxc} : {10'b0, q};
  endfunction

  task automatic push(input string tag, input logic [5:0] q);
    exp_t x;
    x.tag = tag;
    x.rd  = exp_rd(q);
    x.irq = exp_irq(q);
    sbq.push_back(x);
  endtask

  // one bus/event cycle: drive, expect current outputs, advance model
  task automatic step(input string tag, input logic [4:0] t, input logic [4:0] r,
                      input logic [3:0] ev, input logic ird, input logic iwr,
                      input logic iad, input logic [5:0] iwd);
    logic [5:0] set;
    logic       clr;
    @(negedge clk);
    txc = t; rxc = r;
    {ev_err, ev_brk, ev_ovr, ev_rdy} = ev;
    rd = ird; wr = iwr; addr = iad; wd = iwd;
    push(tag, m_q);
    @(posedge clk);
    set = {ev_ovr, ev_brk, ev_err, ev_rdy, (int'(rxc) >= rx_lim(rsel)), (int'(txc) <= tx_lim(tsel))};
    for (int i = 0; i < 6; i++) begin
      clr = wr && !addr && !wd[i] && m_arm[i];
      m_arm[i] = m_q[i] && !clr && (m_arm[i] || (rd && !addr));
      m_q[i]   = set[i] || (m_q[i] && !clr);
    end
  endtask

  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      e = sbq.pop_front();
      checks++;
      if (rdata !== e.rd || {o_err, o_rx, o_brk, o_tx, o_drx, o_dtx, o_any, o_id} !== e.irq) begin
        errors++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", e.tag, rdata,
                 {o_err, o_rx, o_brk, o_tx, o_drx, o_dtx, o_any, o_id}, e.rd, e.irq);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R13: outputs quiet in reset, even with events asserted
    repeat (2) @(negedge clk);
    ev_err = 1; ev_brk = 1; txc = 5'd0;
    push("R13 reset", 6'h00);
    @(negedge clk);
    ev_err = 0; ev_brk = 0; txc = 5'd16;
    push("R13 reset", 6'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 transmit threshold, select 0 -> 8
    step("R1 tx 9 above thr", 5'd9, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    step("R1 tx 9 stays clear", 5'd8, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    step("R1 tx 8 sets flag", 5'd16, 5'd0, 4'b0000, 1, 0, 0, 6'h3F);
    // R4 read-then-write-0 clears; writing 1 is no-op first
    step("R4 write 1 no effect", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h3F);
    step("R4 write 0 after read", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h3E);
    step("R4 cleared", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    // R1 select 3 -> 0
    tsel = 2'd3;
    step("R1 sel3 tx 1", 5'd1, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    step("R1 sel3 tx 0", 5'd0, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    // R6 clear while level holds
    step("R6 read", 5'd0, 5'd0, 4'b0000, 1, 0, 0, 6'h3F);
    step("R6 write 0", 5'd0, 5'd0, 4'b0000, 0, 1, 0, 6'h3E);
    step("R6 still set", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    step("R6 read", 5'd16, 5'd0, 4'b0000, 1, 0, 0, 6'h3F);
    step("R6 clear", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h3E);
    // R2 receive threshold, select 3 -> 14, then select 1 -> 4
    rsel = 2'd3;
    step("R2 rx 13", 5'd16, 5'd13, 4'b0000, 0, 0, 0, 6'h3F);
    step("R2 rx 14", 5'd16, 5'd14, 4'b0000, 0, 0, 0, 6'h3F);
    step("R2 R11 rx full", 5'd16, 5'd0, 4'b0000, 1, 0, 0, 6'h3F);
    step("R2 clear", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h3D);
    rsel = 2'd1;
    step("R2 sel1 rx 3", 5'd16, 5'd3, 4'b0000, 0, 0, 0, 6'h3F);
    step("R2 sel1 rx 4", 5'd16, 5'd4, 4'b0000, 0, 0, 0, 6'h3F);
    step("R2 sel1 set", 5'd16, 5'd0, 4'b0000, 1, 0, 0, 6'h3F);
    step("R2 sel1 clr", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h3D);
    // R7 count register
    step("R7 counts", 5'd11, 5'd2, 4'b0000, 1, 0, 1, 6'h3F);
    step("R7 counts", 5'd16, 5'd16, 4'b0000, 0, 0, 1, 6'h3F);
    step("R7 idle", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    step("R2 clear16", 5'd16, 5'd0, 4'b0000, 1, 0, 0, 6'h3F);
    step("R2 clear16", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h3D);
    // R3 R8 R12 error plus transmit pending
    step("R3 R8 err pulse", 5'd0, 5'd0, 4'b1000, 0, 0, 0, 6'h3F);
    step("R12 err beats tx", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    // R5 write 0 without read
    step("R5 unread write 0", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h00);
    step("R5 still set", 5'd16, 5'd0, 4'b0000, 1, 0, 0, 6'h3F);
    step("R4 clear err", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h37);
    step("R12 tx only", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    step("R10 clr tx", 5'd16, 5'd0, 4'b0000, 1, 0, 0, 6'h3F);
    step("R10 clr tx", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h3E);
    // R9 data-ready in sync mode has no effect on line
    async_m = 1'b0;
    step("R9 rdy pulse sync", 5'd16, 5'd0, 4'b0001, 0, 0, 0, 6'h3F);
    step("R9 sync no irq", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    async_m = 1'b1;
    step("R9 async irq no dma", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    // R10 break and overrun, R12 rx over brk
    step("R10 brk pulse", 5'd16, 5'd0, 4'b0100, 0, 0, 0, 6'h3F);
    step("R12 rx over brk", 5'd16, 5'd0, 4'b0010, 1, 0, 0, 6'h3F);
    step("R4 clear drdy brk", 5'd16, 5'd0, 4'b0000, 0, 1, 0, 6'h2B);
    step("R10 ovr alone", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    // R8 R10 R11 enables gate lines and DMA
    en = 4'b0000;
    step("R8 R11 gated", 5'd0, 5'd5, 4'b1000, 0, 0, 0, 6'h3F);
    step("R8 gated", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    en = 4'b1010;
    step("R11 dma on data only", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    en = 4'b0100;
    step("R10 brk enabled only", 5'd16, 5'd0, 4'b0000, 0, 0, 0, 6'h3F);
    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule